// File: doc/BRIEF.md
# D-Channel Contention Transmit Controller

This block governs when a station may place D-channel bits on a shared multi-device serial bus. A physical-layer device watches the D channel and reports its state once per bus frame through one bit of the command/indication channel. A high indication means a collision or a busy channel, and a low indication means the channel is free. The controller waits for a free indication before it sends the first bit of a frame. While it sends, it keeps watching the indication. On a collision it releases the line and resends the whole frame from its first bit once the channel reads free again.

Frame bytes come from a show-ahead read port. `fb_data` and `fb_eof` describe the current byte. `fb_next` advances to the next byte, and `fb_rewind` returns the pointer to the first byte of the frame. Bits leave on `d_tx`, one for each `slot_stb` pulse. Automatic retry only covers the first `RETRY_BUFS` buffers of `BUF_BYTES` bytes each. A collision after that point ends the frame with a sticky error flag.

States and transitions:
- ST_IDLE goes to ST_WAIT_FREE when `fb_req` is high.
- ST_WAIT_FREE goes to ST_SEND on a low indication.
- ST_SEND goes to ST_ABORT on a collision inside the window.
- ST_SEND goes to ST_DONE on a collision outside the window, which sets `err`.
- ST_SEND goes to ST_DONE after the last bit of the end-of-frame byte.
- ST_ABORT goes to ST_WAIT_FREE.
- ST_DONE goes to ST_IDLE.

Top module: `dct_tx_ctrl`

## Requirements
- R1: After reset the block is in ST_IDLE with `d_tx`=1, `d_en`=0, `err`=0, `done`=0, and `fb_next` and `fb_rewind` both low.
- R2: With `fb_req` high, no bit is driven until an indication pulse (`ind_valid`=1) carries `ind_bit`=0. Pulses with `ind_bit`=1 keep the block waiting, and slot pulses during the wait are not consumed.
- R3: In ST_SEND, each `slot_stb` pulse consumes one bit, and `d_en`=1 during that slot. Bytes go out least significant bit first. `fb_next` pulses once on the free indication that starts the frame, and once on the slot of each byte's last bit when that byte is not the end-of-frame byte.
- R4: After the slot carrying bit 7 of the byte marked `fb_eof`=1, the block spends one cycle in ST_DONE with `done`=1 and then returns to ST_IDLE.
- R5: A high indication during ST_SEND, while the current byte index (counted from 0) is below `RETRY_BUFS*BUF_BYTES`, enters ST_ABORT. There `fb_rewind` pulses for one cycle and `d_en` drops, and the block then goes to ST_WAIT_FREE.
- R6: After an abort, the frame is resent in full, starting with bit 0 of byte 0, once a low indication is seen.
- R7: A high indication during ST_SEND with the byte index at or above `RETRY_BUFS*BUF_BYTES` ends the frame in ST_DONE with no rewind and sets `err`. `err` stays set until ST_IDLE sees `fb_req` high again.
- R8: Outside ST_SEND, `d_en`=0 and `d_tx` is held at the idle level 1, including during ST_ABORT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_req | input | 1 | A frame is ready in the buffer |
| fb_data | input | DW | Current frame byte (show-ahead) |
| fb_eof | input | 1 | Current byte is the last of the frame |
| fb_next | output | 1 | Advance the read pointer by one byte |
| fb_rewind | output | 1 | Return the read pointer to the first byte |
| slot_stb | input | 1 | D-bit transmit slot strobe |
| ind_valid | input | 1 | Indication bit sample strobe (once per bus frame) |
| ind_bit | input | 1 | Sampled collision indication, 1 = busy or collision |
| d_tx | output | 1 | D-channel bit, 1 when released |
| d_en | output | 1 | A frame bit is being driven this slot |
| done | output | 1 | One-cycle frame completion pulse |
| err | output | 1 | Collision occurred beyond the retry window |

## Verification
The bench targets the retry-window edge. A collision after 30 bits (byte index 3) must be retried, and one after 32 bits (byte index 4) must set the error flag. An off-by-one window counter would swap these two outcomes, and the bench would see either a rewind count or an error flag that is wrong. After an abort, every resent bit is compared against the frame from its first bit, so a design that resumes mid-frame or skips the rewind produces wrong slot data. Busy indications held before the first start and after an abort check that no bit leaks out early. A following frame checks that the sticky error flag clears.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_FREE,
        ST_SEND,
        ST_ABORT,
        ST_DONE
    } dct_state_e;
endpackage

// File: rtl/dct_shifter.sv
`timescale 1ns/1ps
// Holds the byte on the line and tracks the bit position inside it.
module dct_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic [DW-1:0] din,
    input  logic          din_eof,
    output logic          bit_out,
    output logic          last_bit,
    output logic          eof_byte
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;

    logic [DW-1:0] sh_q;
    logic [CW-1:0] cnt_q;
    logic          eof_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '1;
            cnt_q <= '0;
            eof_q <= 1'b0;
        end else if (load) begin
            sh_q  <= din;
            cnt_q <= '0;
            eof_q <= din_eof;
        end else if (shift) begin
            sh_q  <= {1'b1, sh_q[DW-1:1]};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bit_out  = sh_q[0];
    assign last_bit = (cnt_q == CW'(DW - 1));
    assign eof_byte = eof_q;
endmodule

// File: rtl/dct_window.sv
`timescale 1ns/1ps
// Counts bytes started in the current attempt; flags the retry window.
module dct_window #(
    parameter int WIN_BYTES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic in_window
);
    localparam int IW = $clog2(WIN_BYTES + 1);

    logic [IW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clear) begin
            idx_q <= '0;
        end else if (inc && (idx_q != IW'(WIN_BYTES))) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign in_window = (idx_q < IW'(WIN_BYTES));
endmodule

// File: rtl/dct_fsm.sv
`timescale 1ns/1ps
module dct_fsm
    import dct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fb_req,
    input  logic ind_valid,
    input  logic ind_bit,
    input  logic slot_stb,
    input  logic last_bit,
    input  logic eof_byte,
    input  logic in_window,
    output logic load,
    output logic shift,
    output logic win_clear,
    output logic win_inc,
    output logic tx_en,
    output logic rewind,
    output logic done,
    output logic err
);
    dct_state_e st_q, st_d;
    logic       err_q, err_d;
    logic       coll, free_ind, slot_take, frame_end;

    assign coll      = ind_valid && ind_bit;
    assign free_ind  = ind_valid && !ind_bit;
    assign slot_take = (st_q == ST_SEND) && slot_stb && !coll;
    assign frame_end = slot_take && last_bit && eof_byte;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            err_q <= err_d;
        end
    end

    // Next state
    always_comb begin
        st_d  = st_q;
        err_d = err_q;
        unique case (st_q)
            ST_IDLE: begin
                if (fb_req) begin
                    st_d  = ST_WAIT_FREE;
                    err_d = 1'b0;
                end
            end
            ST_WAIT_FREE: begin
                if (free_ind) st_d = ST_SEND;
            end
            ST_SEND: begin
                if (coll) begin
                    if (in_window) begin
                        st_d = ST_ABORT;
                    end else begin
                        st_d  = ST_DONE;
                        err_d = 1'b1;
                    end
                end else if (frame_end) begin
                    st_d = ST_DONE;
                end
            end
            ST_ABORT: st_d = ST_WAIT_FREE;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load      = 1'b0;
        win_inc   = 1'b0;
        win_clear = 1'b1;
        tx_en     = 1'b0;
        rewind    = 1'b0;
        done      = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_WAIT_FREE: begin
                load = free_ind;
            end
            ST_SEND: begin
                tx_en     = 1'b1;
                win_clear = 1'b0;
                if (slot_take && last_bit && !eof_byte) begin
                    load    = 1'b1;
                    win_inc = 1'b1;
                end
            end
            ST_ABORT: rewind = 1'b1;
            ST_DONE:  done   = 1'b1;
            default:  ;
        endcase
    end

    assign shift = slot_take;
    assign err   = err_q;
endmodule

// File: rtl/dct_tx_ctrl.sv
`timescale 1ns/1ps
module dct_tx_ctrl #(
    parameter int DW         = 8,
    parameter int BUF_BYTES  = 2,
    parameter int RETRY_BUFS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fb_req,
    input  logic [DW-1:0] fb_data,
    input  logic          fb_eof,
    output logic          fb_next,
    output logic          fb_rewind,
    input  logic          slot_stb,
    input  logic          ind_valid,
    input  logic          ind_bit,
    output logic          d_tx,
    output logic          d_en,
    output logic          done,
    output logic          err
);
    localparam int WIN_BYTES = BUF_BYTES * RETRY_BUFS;

    logic load, shift, win_clear, win_inc, tx_en;
    logic bit_out, last_bit, eof_byte, in_window;

    dct_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fb_req    (fb_req),
        .ind_valid (ind_valid),
        .ind_bit   (ind_bit),
        .slot_stb  (slot_stb),
        .last_bit  (last_bit),
        .eof_byte  (eof_byte),
        .in_window (in_window),
        .load      (load),
        .shift     (shift),
        .win_clear (win_clear),
        .win_inc   (win_inc),
        .tx_en     (tx_en),
        .rewind    (fb_rewind),
        .done      (done),
        .err       (err)
    );

    dct_shifter #(.DW(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .din      (fb_data),
        .din_eof  (fb_eof),
        .bit_out  (bit_out),
        .last_bit (last_bit),
        .eof_byte (eof_byte)
    );

    dct_window #(.WIN_BYTES(WIN_BYTES)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (win_clear),
        .inc       (win_inc),
        .in_window (in_window)
    );

    assign fb_next = load;
    assign d_en    = tx_en;
    assign d_tx    = tx_en ? bit_out : 1'b1;
endmodule

// File: rtl/dct_tx_ctrl_chk.sv
`timescale 1ns/1ps
module dct_tx_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic fb_req,
    input logic fb_next,
    input logic fb_rewind,
    input logic slot_stb,
    input logic ind_valid,
    input logic ind_bit,
    input logic d_tx,
    input logic d_en,
    input logic done,
    input logic err
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!d_en && !err && !fb_rewind && !done));

    p_start_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_en) |-> $past(ind_valid && !ind_bit));

    p_fetch_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fb_next |-> ((ind_valid && !ind_bit) || slot_stb));

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !d_en));

    p_release_on_coll_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (d_en && ind_valid && ind_bit) |=> !d_en);

    p_rewind_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rewind |-> (!d_en && $past(d_en && ind_valid && ind_bit)));

    p_rewind_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rewind |=> !fb_rewind);

    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !fb_req) |=> err);

    p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !d_en |-> d_tx);
endmodule

bind dct_tx_ctrl dct_tx_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fb_req    (fb_req),
    .fb_next   (fb_next),
    .fb_rewind (fb_rewind),
    .slot_stb  (slot_stb),
    .ind_valid (ind_valid),
    .ind_bit   (ind_bit),
    .d_tx      (d_tx),
    .d_en      (d_en),
    .done      (done),
    .err       (err)
);

// File: tb/tb_dct_tx_ctrl.sv
`timescale 1ns/1ps
module tb_dct_tx_ctrl;
    localparam int DW = 8;
    localparam int WIN = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, fb_req, fb_eof, fb_next, fb_rewind;
    logic slot_stb, ind_valid, ind_bit, d_tx, d_en, done, err;
    logic [DW-1:0] fb_data;
    logic [DW-1:0] fr [0:7];
    logic [3:0]    rd_ptr;
    logic [3:0]    frlen;

    int n_checks = 0, n_errors = 0;
    int n_done = 0, n_rew = 0;
    logic q_en[$];
    logic q_b[$];
    int m_st, m_pos;
    logic m_err;

    dct_tx_ctrl dut (
        .clk(clk), .rst_n(rst_n), .fb_req(fb_req), .fb_data(fb_data),
        .fb_eof(fb_eof), .fb_next(fb_next), .fb_rewind(fb_rewind),
        .slot_stb(slot_stb), .ind_valid(ind_valid), .ind_bit(ind_bit),
        .d_tx(d_tx), .d_en(d_en), .done(done), .err(err)
    );

    // Frame source with show-ahead read port
    assign fb_data = fr[rd_ptr[2:0]];
    assign fb_eof  = (rd_ptr == frlen - 4'd1);
    always_ff @(posedge clk) begin
        if (!fb_req || fb_rewind) rd_ptr <= 4'd0;
        else if (fb_next)         rd_ptr <= rd_ptr + 4'd1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pops one expected item per transmit slot
    always begin
        @(negedge clk);
        #5;
        if (rst_n) begin
            if (slot_stb) begin
                if (q_en.size() == 0) begin
                    chk(1'b0, "R3 queue empty", 0, 1);
                end else begin
                    logic e_en, e_b;
                    e_en = q_en.pop_front();
                    e_b  = q_b.pop_front();
                    chk(d_en == e_en, "R2/R3 d_en in slot", int'(d_en), int'(e_en));
                    if (e_en) chk(d_tx == e_b, "R3/R6 bit in slot", int'(d_tx), int'(e_b));
                    else      chk(d_tx == 1'b1, "R8 idle level", int'(d_tx), 1);
                end
            end
            if (done)      n_done++;
            if (fb_rewind) n_rew++;
        end
    end

    task automatic bus_frame(input bit ind);
        @(negedge clk);
        ind_valid = 1'b1;
        ind_bit   = ind;
        if (m_st == 1 && !ind) begin
            m_st = 2;
        end else if (m_st == 2 && ind) begin
            if ((m_pos / 8) < WIN) begin
                m_st = 1; m_pos = 0;
            end else begin
                m_st = 3; m_err = 1'b1;
            end
        end
        @(negedge clk);
        ind_valid = 1'b0;
        ind_bit   = 1'b0;
        if (m_st == 3) fb_req = 1'b0;
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            if (m_st == 2) begin
                q_en.push_back(1'b1);
                q_b.push_back(fr[m_pos / 8][m_pos % 8]);
                m_pos++;
                if (m_pos == int'(frlen) * 8) m_st = 3;
            end else begin
                q_en.push_back(1'b0);
                q_b.push_back(1'b1);
            end
            slot_stb = 1'b1;
            @(negedge clk);
            slot_stb = 1'b0;
            if (m_st == 3) fb_req = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic run_frame(input int len, input int coll_at, input int pre,
                             input int hold, input bit exp_err, input int seed);
        int done0, rew0, hcnt, guard;
        bit collided, ind;
        for (int i = 0; i < 8; i++) fr[i] = DW'((seed * 37 + i * 101 + 13) & 8'hff);
        frlen = 4'(len);
        m_st = 1; m_pos = 0; m_err = 1'b0;
        done0 = n_done; rew0 = n_rew;
        collided = 1'b0; hcnt = pre; guard = 0;
        @(negedge clk);
        fb_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(err == 1'b0, "R7 err cleared on new frame", int'(err), 0);
        while (m_st != 3 && guard < 200) begin
            ind = 1'b0;
            if (m_st == 2 && !collided && coll_at >= 0 && m_pos >= coll_at) begin
                ind = 1'b1; collided = 1'b1; hcnt = hold;
            end else if (m_st == 1 && hcnt > 0) begin
                ind = 1'b1; hcnt--;
            end
            bus_frame(ind);
            guard++;
        end
        repeat (4) @(negedge clk);
        chk(n_done - done0 == 1, "R4 one done pulse", n_done - done0, 1);
        chk(err == exp_err, "R7 err flag", int'(err), int'(exp_err));
        chk(n_rew - rew0 == ((collided && !exp_err) ? 1 : 0), "R5 rewind count",
            n_rew - rew0, (collided && !exp_err) ? 1 : 0);
        chk(d_en == 1'b0 && d_tx == 1'b1, "R8 released after frame", int'(d_en), 0);
    endtask

    initial begin
        #(20 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fb_req = 1'b0; slot_stb = 1'b0;
        ind_valid = 1'b0; ind_bit = 1'b0; frlen = 4'd1;
        for (int i = 0; i < 8; i++) fr[i] = '0;
        repeat (3) @(negedge clk);
        #5;
        chk(d_tx == 1'b1 && d_en == 1'b0, "R1 reset line idle", int'(d_en), 0);
        chk(err == 1'b0 && done == 1'b0, "R1 reset flags", int'(err), 0);
        chk(fb_next == 1'b0 && fb_rewind == 1'b0, "R1 reset strobes", int'(fb_next), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_frame(2, -1, 3, 0, 1'b0, 1);  // R2 busy before start, R3, R4
        run_frame(3, 6, 0, 2, 1'b0, 2);   // R5, R6 early collision
        run_frame(5, 30, 1, 1, 1'b0, 3);  // R5 last bits inside window
        run_frame(6, 32, 0, 0, 1'b1, 4);  // R7 first byte past the window
        run_frame(1, -1, 0, 0, 1'b0, 5);  // R7 err clears, R4 single byte

        chk(q_en.size() == 0, "R3 all slots consumed", q_en.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule